// File: doc/BRIEF.md
# TDM Quadrant Robbed-Bit Forcing Unit

This block sits on one time-division-multiplexed input stream after serial-to-parallel conversion. It receives one 8-bit channel byte per valid strobe. A frame is cut into four quadrants of equal size, each a run of consecutive channels. For each quadrant, a 3-bit code can overwrite the least or the most significant bit of every channel byte with a fixed 0 or 1. This provides robbed-bit signalling. The modified bytes leave the block with the same strobe pattern, one clock later.

The quadrant size follows the selected line rate, so the same control word covers 32, 64, 128 or 256 channels per frame. The control word, the rate select and a bit-error-rate enable are captured on the frame-start pulse and held for the rest of the frame. When the bit-error-rate enable is captured high, the stream is being used for error measurement and no forcing takes place in that frame.

A small state machine tracks the frame position. It has three states:
- `S_WAIT_FRAME`: after reset, no frame seen yet.
- `S_IN_FRAME`: counting channels.
- `S_FRAME_DONE`: the last channel of the frame has been taken.

It has four transitions:
- `S_WAIT_FRAME` to `S_IN_FRAME` on a frame-start pulse.
- `S_IN_FRAME` to `S_FRAME_DONE` when the byte of the last channel is accepted.
- `S_FRAME_DONE` to `S_IN_FRAME` on a frame-start pulse.
- `S_IN_FRAME` back to `S_IN_FRAME` (channel count restarted) on a frame-start pulse that arrives before the frame ends.

Top module: `qrb_force_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_data` are 0.
- R2: `out_valid` equals `in_valid` of the previous clock. A byte whose quadrant code has bit 2 at 0 (codes 000 to 011) appears on `out_data` unchanged, one clock after it was presented.
- R3: `rate_sel` 0, 1, 2 and 3 give 32, 64, 128 and 256 channels per frame. Channel c falls in quadrant c / (8 << rate_sel).
- R4: The code of quadrant q is `quad_ctrl[3q+2:3q]`. Quadrant 0 uses bits 2:0 and quadrant 3 uses bits 11:9.
- R5: Code 100 sets bit 0 of the byte to 0, and code 101 sets it to 1. Bits 7:1 pass unchanged.
- R6: Code 110 sets bit 7 of the byte to 0, and code 111 sets it to 1. Bits 6:0 pass unchanged.
- R7: If `ber_en` is 1 when the frame starts, every byte of that frame passes unchanged, whatever the codes are.
- R8: `quad_ctrl`, `rate_sel` and `ber_en` are sampled only in the cycle where `frame_start` is 1. Changing them mid-frame has no effect until the next frame start.
- R9: A byte presented together with `frame_start` is channel 0. Each later valid byte is the next channel. A `frame_start` in the middle of a frame restarts the count at 0.
- R10: Bytes are not forced if they arrive before the first frame start after reset, or after the last channel of a frame and before the next frame start.
- R11: While `in_valid` is 0, `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame-start pulse; the byte in the same cycle, if any, is channel 0 |
| rate_sel | input | 2 | Line rate: 0=32, 1=64, 2=128, 3=256 channels per frame |
| quad_ctrl | input | 12 | Four 3-bit quadrant codes, quadrant 0 in the low bits |
| ber_en | input | 1 | Stream is in error-rate reception; disables forcing for the frame |
| in_valid | input | 1 | Channel byte strobe |
| in_data | input | 8 | Channel byte |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_data | output | 8 | Channel byte after forcing |

## Verification
Every line rate is driven through a full frame with a different code in each quadrant. The data pattern contains 00, FF and mixed bytes, so a wrong quadrant boundary, a swapped field or an LSB/MSB mix-up changes a visible bit. The same forcing word is also run with the error-rate enable set, and with pass-through codes whose low bits are not zero. This separates the active-code decode from a test on the low bits.

Other directed runs cover:
- configuration changed mid-frame, which only the next frame may pick up;
- a frame start arriving early, after which channel 0's code must apply at once;
- bytes sent before any frame and after the last channel, which must pass untouched;
- idle gaps, which must keep the output byte stable.

// File: rtl/qrb_pkg.sv
package qrb_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        S_WAIT_FRAME = 2'd0,
        S_IN_FRAME   = 2'd1,
        S_FRAME_DONE = 2'd2
    } qrb_state_e;

    // bit 2: forcing active, bit 1: 1 = MSB / 0 = LSB, bit 0: forced value
    function automatic logic code_active(input logic [CODE_W-1:0] c);
        return c[2];
    endfunction

    function automatic logic code_hits_msb(input logic [CODE_W-1:0] c);
        return c[1];
    endfunction

    function automatic logic code_value(input logic [CODE_W-1:0] c);
        return c[0];
    endfunction

endpackage

// File: rtl/qrb_frame_fsm.sv
module qrb_frame_fsm
    import qrb_pkg::*;
#(
    parameter int BASE_CH   = 32,
    parameter int NUM_RATES = 4,
    parameter int NUM_Q     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic                          in_valid,
    input  logic [$clog2(NUM_RATES)-1:0]  rate_sel,
    input  logic [NUM_Q*CODE_W-1:0]       quad_ctrl,
    input  logic                          ber_en,
    output logic [$clog2(BASE_CH)+NUM_RATES-2:0] eff_ch,
    output logic [$clog2(NUM_RATES)-1:0]  eff_rate,
    output logic [NUM_Q*CODE_W-1:0]       eff_ctrl,
    output logic                          eff_ber,
    output logic                          force_ok,
    output qrb_state_e                    st_q,
    output logic [$clog2(BASE_CH)+NUM_RATES-2:0] cnt_q,
    output logic [NUM_Q*CODE_W-1:0]       ctrl_q
);

    localparam int CNT_W  = $clog2(BASE_CH) + NUM_RATES - 1;
    localparam int RATE_W = $clog2(NUM_RATES);
    localparam int CTRL_W = NUM_Q * CODE_W;

    qrb_state_e         st_d;
    logic [CNT_W-1:0]   cnt_d;
    logic [RATE_W-1:0]  rate_q;
    logic               ber_q;
    logic [CNT_W-1:0]   last_ch;
    logic               take_last;

    // state register and frame-start configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_WAIT_FRAME;
            cnt_q  <= '0;
            rate_q <= '0;
            ctrl_q <= '0;
            ber_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (frame_start) begin
                rate_q <= rate_sel;
                ctrl_q <= quad_ctrl;
                ber_q  <= ber_en;
            end
        end
    end

    assign last_ch   = CNT_W'((BASE_CH << rate_q) - 1);
    assign take_last = in_valid && (cnt_q == last_ch);

    // next state and channel count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            S_WAIT_FRAME: begin
                if (frame_start) begin
                    st_d  = S_IN_FRAME;
                    cnt_d = CNT_W'(in_valid);
                end
            end
            S_IN_FRAME: begin
                if (frame_start) begin
                    cnt_d = CNT_W'(in_valid);
                end else if (take_last) begin
                    st_d = S_FRAME_DONE;
                end else if (in_valid) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_FRAME_DONE: begin
                if (frame_start) begin
                    st_d  = S_IN_FRAME;
                    cnt_d = CNT_W'(in_valid);
                end
            end
            default: begin
                st_d  = S_WAIT_FRAME;
                cnt_d = '0;
            end
        endcase
    end

    // outputs: the values that govern the byte of this cycle
    always_comb begin
        eff_ch   = frame_start ? '0 : cnt_q;
        eff_rate = frame_start ? rate_sel : rate_q;
        eff_ctrl = frame_start ? quad_ctrl : ctrl_q;
        eff_ber  = frame_start ? ber_en : ber_q;
        force_ok = (frame_start || (st_q == S_IN_FRAME)) && !eff_ber;
    end

endmodule

// File: rtl/qrb_quad_sel.sv
module qrb_quad_sel
    import qrb_pkg::*;
#(
    parameter int BASE_CH   = 32,
    parameter int NUM_RATES = 4,
    parameter int NUM_Q     = 4
) (
    input  logic [$clog2(BASE_CH)+NUM_RATES-2:0] ch,
    input  logic [$clog2(NUM_RATES)-1:0]         rate,
    input  logic [NUM_Q*CODE_W-1:0]              ctrl,
    output logic [CODE_W-1:0]                    code
);

    localparam int Q_W        = $clog2(NUM_Q);
    localparam int BASE_SHIFT = $clog2(BASE_CH) - Q_W;

    logic [Q_W-1:0]    q_by_rate [NUM_RATES];
    logic [CODE_W-1:0] fields    [NUM_Q];
    logic [Q_W-1:0]    q_idx;

    // quadrant = top Q_W bits of the channel number for each rate
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        assign q_by_rate[r] = ch[BASE_SHIFT + r +: Q_W];
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_field
        assign fields[q] = ctrl[q*CODE_W +: CODE_W];
    end

    assign q_idx = q_by_rate[rate];
    assign code  = fields[q_idx];

endmodule

// File: rtl/qrb_bit_force.sv
module qrb_bit_force
    import qrb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              enable,
    input  logic [CODE_W-1:0] code,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);

    always_comb begin
        dout = din;
        if (enable && code_active(code)) begin
            if (code_hits_msb(code)) begin
                dout[BYTE_W-1] = code_value(code);
            end else begin
                dout[0] = code_value(code);
            end
        end
    end

endmodule

// File: rtl/qrb_force_top.sv
module qrb_force_top
    import qrb_pkg::*;
#(
    parameter int BASE_CH   = 32,
    parameter int NUM_RATES = 4,
    parameter int NUM_Q     = 4,
    parameter int BYTE_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start,
    input  logic [$clog2(NUM_RATES)-1:0]  rate_sel,
    input  logic [NUM_Q*CODE_W-1:0]       quad_ctrl,
    input  logic                          ber_en,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_data,
    output logic                          out_valid,
    output logic [BYTE_W-1:0]             out_data
);

    localparam int CNT_W  = $clog2(BASE_CH) + NUM_RATES - 1;
    localparam int RATE_W = $clog2(NUM_RATES);
    localparam int CTRL_W = NUM_Q * CODE_W;

    logic [CNT_W-1:0]  eff_ch;
    logic [RATE_W-1:0] eff_rate;
    logic [CTRL_W-1:0] eff_ctrl;
    logic              eff_ber;
    logic              force_ok;
    qrb_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CODE_W-1:0] code;
    logic [BYTE_W-1:0] forced;

    qrb_frame_fsm #(
        .BASE_CH   (BASE_CH),
        .NUM_RATES (NUM_RATES),
        .NUM_Q     (NUM_Q)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .rate_sel    (rate_sel),
        .quad_ctrl   (quad_ctrl),
        .ber_en      (ber_en),
        .eff_ch      (eff_ch),
        .eff_rate    (eff_rate),
        .eff_ctrl    (eff_ctrl),
        .eff_ber     (eff_ber),
        .force_ok    (force_ok),
        .st_q        (st_q),
        .cnt_q       (cnt_q),
        .ctrl_q      (ctrl_q)
    );

    qrb_quad_sel #(
        .BASE_CH   (BASE_CH),
        .NUM_RATES (NUM_RATES),
        .NUM_Q     (NUM_Q)
    ) sel_i (
        .ch   (eff_ch),
        .rate (eff_rate),
        .ctrl (eff_ctrl),
        .code (code)
    );

    qrb_bit_force #(
        .BYTE_W (BYTE_W)
    ) frc_i (
        .enable (force_ok),
        .code   (code),
        .din    (in_data),
        .dout   (forced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= forced;
            end
        end
    end

endmodule

// File: rtl/qrb_force_checker.sv
module qrb_force_checker
    import qrb_pkg::*;
#(
    parameter int BASE_CH   = 32,
    parameter int NUM_RATES = 4,
    parameter int NUM_Q     = 4,
    parameter int BYTE_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 frame_start,
    input  logic                                 in_valid,
    input  logic [BYTE_W-1:0]                    in_data,
    input  logic                                 out_valid,
    input  logic [BYTE_W-1:0]                    out_data,
    input  logic                                 eff_ber,
    input  qrb_state_e                           st_q,
    input  logic [$clog2(BASE_CH)+NUM_RATES-2:0] cnt_q,
    input  logic [NUM_Q*CODE_W-1:0]              ctrl_q
);

    localparam int CNT_W = $clog2(BASE_CH) + NUM_RATES - 1;

    always_comb begin
        if (!rst_n) begin
            assert_reset_out_R1: assert (!out_valid && out_data == '0);
        end
    end

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // forcing never touches the bits between LSB and MSB
    assert_mid_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data[BYTE_W-2:1] == $past(in_data[BYTE_W-2:1]));

    assert_ber_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_ber) |=> out_data == $past(in_data));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ctrl_q));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> cnt_q == CNT_W'($past(in_valid)));

    assert_outside_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frame_start && st_q != S_IN_FRAME) |=> out_data == $past(in_data));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

endmodule

bind qrb_force_top qrb_force_checker #(
    .BASE_CH   (BASE_CH),
    .NUM_RATES (NUM_RATES),
    .NUM_Q     (NUM_Q),
    .BYTE_W    (BYTE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .eff_ber     (eff_ber),
    .st_q        (st_q),
    .cnt_q       (cnt_q),
    .ctrl_q      (ctrl_q)
);

// File: tb/qrb_force_top_tb_top.sv
module qrb_force_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  rate_sel = '0;
    logic [11:0] quad_ctrl = '0;
    logic        ber_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [7:0]  out_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qrb_force_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .rate_sel    (rate_sel),
        .quad_ctrl   (quad_ctrl),
        .ber_en      (ber_en),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    // codes: QF_* = force value to LSB (4/5) or MSB (6/7)
    localparam logic [11:0] CTRL_ALL = {3'b111, 3'b110, 3'b101, 3'b100};
    localparam logic [11:0] CTRL_REV = {3'b100, 3'b101, 3'b110, 3'b111};
    localparam logic [11:0] CTRL_OFF = {3'b011, 3'b010, 3'b001, 3'b000};

    function automatic logic [7:0] model(input logic [7:0] d, input int ch, input int rate,
                                         input logic [11:0] ctrl, input bit ber);
        int q;
        logic [2:0] c;
        logic [7:0] r;
        r = d;
        if (ber || ch >= (32 << rate)) return r;
        q = ch / (8 << rate);
        c = ctrl[3*q +: 3];
        if (c[2]) begin
            if (c[1]) r[7] = c[0];
            else      r[0] = c[0];
        end
        return r;
    endfunction

    function automatic logic [7:0] pattern(input int i, input int seed);
        case (i % 4)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h5A ^ 8'(seed);
            default: return 8'(i * 37 + seed);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_frame(input int rate, input logic [11:0] ctrl, input bit ber,
                             input int nbytes, input int mid, input int rate2,
                             input logic [11:0] ctrl2, input bit ber2,
                             input int seed, input string tag);
        logic [7:0] d, e;
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            frame_start = (i == 0);
            if (i < mid) begin
                rate_sel = 2'(rate); quad_ctrl = ctrl; ber_en = ber;
            end else begin
                rate_sel = 2'(rate2); quad_ctrl = ctrl2; ber_en = ber2;
            end
            d = pattern(i, seed);
            in_valid = 1'b1;
            in_data  = d;
            @(posedge clk); #1;
            e = model(d, i, rate, ctrl, ber);
            check(out_valid && out_data == e, tag, {out_valid, out_data}, {1'b1, e});
        end
        @(negedge clk);
        frame_start = 1'b0;
        in_valid    = 1'b0;
    endtask

    task automatic send_loose(input int n, input int seed, input string tag);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_start = 1'b0;
            d = pattern(i, seed);
            in_valid = 1'b1;
            in_data  = d;
            @(posedge clk); #1;
            check(out_valid && out_data == d, tag, {out_valid, out_data}, {1'b1, d});
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        #1;
        check(!out_valid && out_data == 8'h00, "R1 reset outputs", {out_valid, out_data}, 9'h000);
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && out_data == 8'h00, "R1 reset held", {out_valid, out_data}, 9'h000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_before_first_frame();
        quad_ctrl = CTRL_ALL; rate_sel = 2'd0; ber_en = 1'b0;
        send_loose(6, 3, "R10 before first frame");
    endtask

    task automatic test_passthrough();
        run_frame(0, CTRL_OFF, 0, 32, 32, 0, CTRL_OFF, 0, 1, "R2 codes 0xx pass");
    endtask

    task automatic test_rates();
        for (int r = 0; r < 4; r++) begin
            run_frame(r, CTRL_ALL, 0, 32 << r, 32 << r, r, CTRL_ALL, 0, r, "R3 R4 R5 R6 rate sweep");
            run_frame(r, CTRL_REV, 0, 32 << r, 32 << r, r, CTRL_REV, 0, r + 9, "R4 R5 R6 reversed codes");
        end
    endtask

    task automatic test_ber();
        run_frame(1, CTRL_ALL, 1, 64, 64, 1, CTRL_ALL, 1, 5, "R7 ber bypass");
    endtask

    task automatic test_mid_change();
        run_frame(0, CTRL_ALL, 0, 32, 10, 2, 12'hFFF, 1, 7, "R8 mid-frame change ignored");
        run_frame(2, 12'hFFF, 0, 128, 128, 2, 12'hFFF, 0, 8, "R8 new config next frame");
    endtask

    task automatic test_restart();
        run_frame(0, {3'b000, 3'b000, 3'b110, 3'b101}, 0, 12, 12, 0,
                  {3'b000, 3'b000, 3'b110, 3'b101}, 0, 2, "R9 partial frame");
        run_frame(0, {3'b000, 3'b000, 3'b110, 3'b101}, 0, 32, 32, 0,
                  {3'b000, 3'b000, 3'b110, 3'b101}, 0, 4, "R9 restart at channel 0");
    endtask

    task automatic test_after_end();
        run_frame(0, CTRL_ALL, 0, 36, 36, 0, CTRL_ALL, 0, 6, "R10 bytes past last channel");
        send_loose(4, 11, "R10 done state pass");
    endtask

    task automatic test_idle_hold();
        logic [7:0] last;
        run_frame(0, CTRL_ALL, 0, 2, 2, 0, CTRL_ALL, 0, 1, "R11 setup");
        last = out_data;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_data = 8'hA5 ^ 8'(k);
            @(posedge clk); #1;
            check(!out_valid && out_data == last, "R11 R2 idle hold",
                  {out_valid, out_data}, {1'b0, last});
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        test_reset();
        test_before_first_frame();
        test_passthrough();
        test_rates();
        test_ber();
        test_mid_change();
        test_restart();
        test_after_end();
        test_idle_hold();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule